// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a 32-bit processor that completes each instruction in one clock: fetch, decode, execute, memory access and register write-back all happen between two rising edges. It executes a small fixed subset of a classic 32-bit load/store instruction encoding. That subset covers register-register arithmetic and logic, immediate add, immediate exclusive-or, load-upper-immediate, signed byte load, word store, branch-on-equal and absolute jump.

The core drives a word address to an instruction memory and expects the instruction word back in the same cycle. Its data side presents a byte address, write data and a write strobe, and it reads back a 32-bit word combinationally. An external address decoder normally sits on that data port and steers accesses to RAM or to memory-mapped peripherals. Byte loads pick their lane from the returned word inside the core, so the memory side only ever deals in whole words.

The core holds no state besides the program counter and the register file. There is no state machine: every control signal is decoded afresh from the current instruction word.

Top module: `sc32_core`

## Requirements
- R1: While `rst` is high the program counter is 0, `imem_addr` is 0, `dmem_we` is low and no register is written. In the first cycle after `rst` falls, the instruction at word 0 executes.
- R2: R-type opcode 0x00 (rs in bits 25:21, rt in 20:16, rd in 15:11, funct in 5:0). Funct 0x20 and 0x21 write rs+rt to rd, and funct 0x22 and 0x23 write rs-rt to rd. All four wrap modulo 2^32 and never trap.
- R3: R-type funct 0x24, 0x25 and 0x26 write rs AND rt, rs OR rt and rs XOR rt to rd.
- R4: R-type funct 0x2A writes 1 to rd when rs < rt as signed two's-complement numbers, and 0 otherwise.
- R5: Opcode 0x0E writes rs XOR the zero-extended 16-bit immediate (bits 15:0) to rt.
- R6: Opcode 0x09 writes rs + sign-extended immediate to rt. Opcode 0x0F writes the immediate to rt bits 31:16 and clears bits 15:0.
- R7: Opcode 0x20 reads the word at byte address rs + sign-extended offset. It selects the byte given by address bits 1:0 in big-endian order (lane 0 = bits 31:24, lane 3 = bits 7:0), sign-extends it from its bit 7 and writes the result to rt.
- R8: Opcode 0x2B raises `dmem_we` for exactly that one cycle. `dmem_addr` = rs + sign-extended offset, `dmem_wdata` = rt, and no register is written.
- R9: Opcode 0x04 compares rs and rt. When they are equal, the next PC = PC+4 + (sign-extended immediate << 2). Otherwise the next PC = PC+4.
- R10: Opcode 0x02 sets the next PC to {(PC+4)[31:28], index[25:0], 2'b00}. The image 0x3C020000, 0x24420055, 0x3C03FFFF, 0x24632008, 0xAC620000, 0x08000005 performs one store of 0x55 to 0xFFFF2008 and then stays at word 5.
- R11: Register 0 always reads as zero, and writes to it are discarded.
- R12: An opcode or R-type funct not listed above writes no register, makes no store and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | IMEM_AW | Word address of the instruction being executed |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, one cycle per store |
| dmem_rdata | input | 32 | Word at `dmem_addr`, same cycle |

## Verification
The arithmetic and logic paths are swept over every ordered pair drawn from eight operands. The operands include zero, one, all-ones, the most negative and most positive values, and values whose low half has bit 15 set. This separates wrap-around from saturation, signed from unsigned comparison, and zero-extension from sign-extension of the same immediate. Byte loads read every lane of words whose bytes alternate in sign, plus one load through a negative offset, which exposes any lane reversal or wrong sign bit. Taken and not-taken branches, writes aimed at register 0 and undefined encodings are each followed by stores that make the register state visible at the data port.

// File: rtl/sc32_pkg.sv
package sc32_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;

    typedef enum logic [5:0] {
        OP_RTYPE = 6'h00,
        OP_JUMP  = 6'h02,
        OP_BEQ   = 6'h04,
        OP_ADDIU = 6'h09,
        OP_XORI  = 6'h0E,
        OP_LUI   = 6'h0F,
        OP_LB    = 6'h20,
        OP_SW    = 6'h2B
    } opcode_e;

    typedef enum logic [5:0] {
        FN_ADD  = 6'h20,
        FN_ADDU = 6'h21,
        FN_SUB  = 6'h22,
        FN_SUBU = 6'h23,
        FN_AND  = 6'h24,
        FN_OR   = 6'h25,
        FN_XOR  = 6'h26,
        FN_SLT  = 6'h2A
    } funct_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_XOR,
        ALU_SLT,
        ALU_PASSB
    } alu_op_e;

    typedef enum logic [1:0] {
        IMM_SEXT,
        IMM_ZEXT,
        IMM_UPPER
    } imm_kind_e;

    typedef struct packed {
        logic      reg_we;
        logic      dst_is_rd;
        logic      b_is_imm;
        imm_kind_e imm_kind;
        alu_op_e   alu_op;
        logic      mem_we;
        logic      wb_from_mem;
        logic      branch;
        logic      jump;
    } ctrl_t;

endpackage

// File: rtl/sc32_decode.sv
module sc32_decode
    import sc32_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl          = '0;
        ctrl.imm_kind = IMM_SEXT;
        ctrl.alu_op   = ALU_ADD;
        unique case (opcode)
            OP_RTYPE: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_we    = 1'b1;
                unique case (funct)
                    FN_ADD, FN_ADDU: ctrl.alu_op = ALU_ADD;
                    FN_SUB, FN_SUBU: ctrl.alu_op = ALU_SUB;
                    FN_AND:          ctrl.alu_op = ALU_AND;
                    FN_OR:           ctrl.alu_op = ALU_OR;
                    FN_XOR:          ctrl.alu_op = ALU_XOR;
                    FN_SLT:          ctrl.alu_op = ALU_SLT;
                    default:         ctrl.reg_we = 1'b0;
                endcase
            end
            OP_ADDIU: begin
                ctrl.reg_we   = 1'b1;
                ctrl.b_is_imm = 1'b1;
            end
            OP_XORI: begin
                ctrl.reg_we   = 1'b1;
                ctrl.b_is_imm = 1'b1;
                ctrl.imm_kind = IMM_ZEXT;
                ctrl.alu_op   = ALU_XOR;
            end
            OP_LUI: begin
                ctrl.reg_we   = 1'b1;
                ctrl.b_is_imm = 1'b1;
                ctrl.imm_kind = IMM_UPPER;
                ctrl.alu_op   = ALU_PASSB;
            end
            OP_LB: begin
                ctrl.reg_we      = 1'b1;
                ctrl.b_is_imm    = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OP_SW: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.mem_we   = 1'b1;
            end
            OP_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OP_JUMP: begin
                ctrl.jump = 1'b1;
            end
            default: begin
                ctrl.reg_we = 1'b0;
            end
        endcase
    end

    // R12: an undefined encoding may never both store and write a register
    always_comb begin
        a_r12_store_or_write: assert (!(ctrl.mem_we && ctrl.reg_we));
    end

endmodule

// File: rtl/sc32_alu.sv
module sc32_alu
    import sc32_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    logic signed_lt;

    always_comb begin
        signed_lt = ($signed(a) < $signed(b));
        unique case (op)
            ALU_ADD:   y = a + b;
            ALU_SUB:   y = a - b;
            ALU_AND:   y = a & b;
            ALU_OR:    y = a | b;
            ALU_XOR:   y = a ^ b;
            ALU_SLT:   y = {{(W-1){1'b0}}, signed_lt};
            ALU_PASSB: y = b;
            default:   y = '0;
        endcase
    end

    // R4: the compare result is a single bit
    always_comb begin
        if (op == ALU_SLT) begin
            a_r4_slt_bool: assert (y[W-1:1] == '0);
        end
    end

endmodule

// File: rtl/sc32_regfile.sv
module sc32_regfile
    import sc32_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int AW = RIDX
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);

    localparam int NREG = 1 << AW;

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

endmodule

// File: rtl/sc32_core.sv
module sc32_core
    import sc32_pkg::*;
#(
    parameter int IMEM_AW = 8
) (
    input  logic               clk,
    input  logic               rst,
    output logic [IMEM_AW-1:0] imem_addr,
    input  logic [31:0]        imem_data,
    output logic [31:0]        dmem_addr,
    output logic [31:0]        dmem_wdata,
    output logic               dmem_we,
    input  logic [31:0]        dmem_rdata
);

    localparam int W  = XLEN;
    localparam int RA = RIDX;

    logic [W-1:0]  pc, pc_next, pc_plus4, br_target, j_target;
    logic [5:0]    f_op, f_funct;
    logic [RA-1:0] f_rs, f_rt, f_rd, dst;
    logic [15:0]   f_imm;
    logic [25:0]   f_index;
    logic [4:0]    unused_shamt;
    ctrl_t         ctrl;
    logic [W-1:0]  rs_val, rt_val, imm_sext, imm_ext, alu_b, alu_y;
    logic [7:0]    lane_byte;
    logic [W-1:0]  load_val, wb_val;
    logic          rf_we, take_branch;

    // instruction fields
    assign f_op         = imem_data[31:26];
    assign f_rs         = imem_data[25:21];
    assign f_rt         = imem_data[20:16];
    assign f_rd         = imem_data[15:11];
    assign unused_shamt = imem_data[10:6];
    assign f_funct      = imem_data[5:0];
    assign f_imm        = imem_data[15:0];
    assign f_index      = imem_data[25:0];

    sc32_decode u_dec (
        .opcode (f_op),
        .funct  (f_funct),
        .ctrl   (ctrl)
    );

    assign dst   = ctrl.dst_is_rd ? f_rd : f_rt;
    assign rf_we = ctrl.reg_we & ~rst;

    sc32_regfile #(.W(W), .AW(RA)) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (dst),
        .wdata   (wb_val),
        .raddr_a (f_rs),
        .raddr_b (f_rt),
        .rdata_a (rs_val),
        .rdata_b (rt_val)
    );

    // immediate shaping
    assign imm_sext = {{(W-16){f_imm[15]}}, f_imm};

    always_comb begin
        unique case (ctrl.imm_kind)
            IMM_SEXT:  imm_ext = imm_sext;
            IMM_ZEXT:  imm_ext = {{(W-16){1'b0}}, f_imm};
            IMM_UPPER: imm_ext = {f_imm, {(W-16){1'b0}}};
            default:   imm_ext = imm_sext;
        endcase
    end

    assign alu_b = ctrl.b_is_imm ? imm_ext : rt_val;

    sc32_alu #(.W(W)) u_alu (
        .op (ctrl.alu_op),
        .a  (rs_val),
        .b  (alu_b),
        .y  (alu_y)
    );

    // data port
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_we & ~rst;

    // byte lane select, big-endian lane order
    always_comb begin
        unique case (alu_y[1:0])
            2'd0:    lane_byte = dmem_rdata[31:24];
            2'd1:    lane_byte = dmem_rdata[23:16];
            2'd2:    lane_byte = dmem_rdata[15:8];
            default: lane_byte = dmem_rdata[7:0];
        endcase
    end

    assign load_val = {{(W-8){lane_byte[7]}}, lane_byte};
    assign wb_val   = ctrl.wb_from_mem ? load_val : alu_y;

    // next-PC selection
    assign pc_plus4    = pc + 32'd4;
    assign br_target   = pc_plus4 + {imm_sext[W-3:0], 2'b00};
    assign j_target    = {pc_plus4[31:28], f_index, 2'b00};
    assign take_branch = ctrl.branch && (alu_y == '0);

    always_comb begin
        if (ctrl.jump) begin
            pc_next = j_target;
        end else if (take_branch) begin
            pc_next = br_target;
        end else begin
            pc_next = pc_plus4;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else begin
            pc <= pc_next;
        end
    end

    assign imem_addr = pc[IMEM_AW+1:2];

    // R1: reset returns the program counter to zero
    a_r1_pc_cleared: assert property (@(posedge clk) rst |=> (pc == '0));

    // R12: without jump or taken branch the PC steps by one word
    a_r12_pc_step: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.jump && !ctrl.branch) |=> (pc == $past(pc) + 32'd4));

    // R8: a store never writes the register file
    a_r8_store_no_regwrite: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> !rf_we);

    // R9: equal operands on a branch redirect by the scaled offset
    a_r9_branch_target: assert property (@(posedge clk) disable iff (rst)
        (ctrl.branch && (rs_val == rt_val)) |=>
        (pc == $past(pc) + 32'd4 + {$past(imm_sext[W-3:0]), 2'b00}));

    // R10: a jump lands on the index from the instruction word
    a_r10_jump_target: assert property (@(posedge clk) disable iff (rst)
        ctrl.jump |=> (pc[27:0] == {$past(f_index), 2'b00}));

    // R7: byte loads write a properly sign-extended value
    a_r7_lb_sign: assert property (@(posedge clk) disable iff (rst)
        ctrl.wb_from_mem |-> (wb_val[W-1:8] == {(W-8){dmem_rdata[8*(3-alu_y[1:0]) + 7]}}));

endmodule

// File: tb/sc32_core_test.sv
`timescale 1ns/1ps
module sc32_core_test;

    localparam int IAW = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [IAW-1:0] imem_addr;
    logic [31:0]    imem_data;
    logic [31:0]    dmem_addr, dmem_wdata, dmem_rdata;
    logic           dmem_we;

    logic [31:0] imem [1 << IAW];
    logic [31:0] dmem [64];
    int          nstores = 0;
    logic [31:0] last_a = '0, last_d = '0;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sc32_core #(.IMEM_AW(IAW)) uut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_data  = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) begin
            dmem[dmem_addr[7:2]] <= dmem_wdata;
            nstores <= nstores + 1;
            last_a  <= dmem_addr;
            last_d  <= dmem_wdata;
        end
    end

    function automatic logic [31:0] e_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] e_i(input logic [5:0] op, input int rt, input int rs, input logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction

    function automatic logic [31:0] e_j(input int idx);
        return {6'h02, idx[25:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic clear_imem();
        for (int i = 0; i < (1 << IAW); i++) imem[i] = 32'h0000003F;
    endtask

    task automatic restart();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [31:0] ops [8];
    logic [31:0] snap [4];

    initial begin
        int s0;
        ops[0] = 32'h0000_0000; ops[1] = 32'h0000_0001;
        ops[2] = 32'hFFFF_FFFF; ops[3] = 32'h8000_0000;
        ops[4] = 32'h7FFF_FFFF; ops[5] = 32'h1234_5678;
        ops[6] = 32'hFFFF_8000; ops[7] = 32'h0000_7FFF;
        for (int i = 0; i < 64; i++) dmem[i] = '0;

        // R1: reset behaviour, first instruction is a store
        clear_imem();
        imem[0] = e_i(6'h2B, 0, 0, 16'h00F0);
        imem[1] = e_j(1);
        repeat (3) @(negedge clk);
        chk("R1 imem_addr in reset", 32'(imem_addr), 32'd0);
        chk("R1 no store in reset", 32'(dmem_we), 32'd0);
        chk("R1 store count in reset", 32'(nstores), 32'd0);
        rst = 1'b0;
        #1;
        chk("R1 word 0 runs after reset", 32'(dmem_we), 32'd1);
        chk("R1 fetch word 0", 32'(imem_addr), 32'd0);

        // R10: fixed six-word image
        clear_imem();
        imem[0] = 32'h3C020000; imem[1] = 32'h24420055;
        imem[2] = 32'h3C03FFFF; imem[3] = 32'h24632008;
        imem[4] = 32'hAC620000; imem[5] = 32'h08000005;
        restart();
        s0 = nstores;
        run(20);
        chk("R10 store address", last_a, 32'hFFFF2008);
        chk("R10 store data", last_d, 32'h00000055);
        chk("R10 single store", 32'(nstores - s0), 32'd1);
        chk("R10 loop word", 32'(imem_addr), 32'd5);
        run(3);
        chk("R10 loop stays", 32'(imem_addr), 32'd5);

        // R2..R6, R8: operand sweep
        for (int ia = 0; ia < 8; ia++) begin
            for (int ib = 0; ib < 8; ib++) begin
                logic [31:0] a, b, sb;
                a = ops[ia];
                b = ops[ib];
                sb = {{16{b[15]}}, b[15:0]};
                clear_imem();
                imem[0]  = e_i(6'h0F, 1, 0, a[31:16]);
                imem[1]  = e_i(6'h0E, 1, 1, a[15:0]);
                imem[2]  = e_i(6'h0F, 2, 0, b[31:16]);
                imem[3]  = e_i(6'h0E, 2, 2, b[15:0]);
                imem[4]  = e_r(6'h20, 3, 1, 2); imem[5]  = e_i(6'h2B, 3, 0, 16'd0);
                imem[6]  = e_r(6'h21, 3, 1, 2); imem[7]  = e_i(6'h2B, 3, 0, 16'd4);
                imem[8]  = e_r(6'h22, 3, 1, 2); imem[9]  = e_i(6'h2B, 3, 0, 16'd8);
                imem[10] = e_r(6'h23, 3, 1, 2); imem[11] = e_i(6'h2B, 3, 0, 16'd12);
                imem[12] = e_r(6'h24, 3, 1, 2); imem[13] = e_i(6'h2B, 3, 0, 16'd16);
                imem[14] = e_r(6'h25, 3, 1, 2); imem[15] = e_i(6'h2B, 3, 0, 16'd20);
                imem[16] = e_r(6'h26, 3, 1, 2); imem[17] = e_i(6'h2B, 3, 0, 16'd24);
                imem[18] = e_r(6'h2A, 3, 1, 2); imem[19] = e_i(6'h2B, 3, 0, 16'd28);
                imem[20] = e_i(6'h0E, 4, 1, b[15:0]); imem[21] = e_i(6'h2B, 4, 0, 16'd32);
                imem[22] = e_i(6'h09, 4, 1, b[15:0]); imem[23] = e_i(6'h2B, 4, 0, 16'd36);
                imem[24] = e_i(6'h0F, 4, 0, b[15:0]); imem[25] = e_i(6'h2B, 4, 0, 16'd40);
                imem[26] = e_j(26);
                restart();
                s0 = nstores;
                run(30);
                chk("R2 add", dmem[0], a + b);
                chk("R2 addu", dmem[1], a + b);
                chk("R2 sub", dmem[2], a - b);
                chk("R2 subu", dmem[3], a - b);
                chk("R3 and", dmem[4], a & b);
                chk("R3 or", dmem[5], a | b);
                chk("R3 xor", dmem[6], a ^ b);
                chk("R4 slt", dmem[7], ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
                chk("R5 xori", dmem[8], a ^ {16'h0, b[15:0]});
                chk("R6 addiu", dmem[9], a + sb);
                chk("R6 lui", dmem[10], {b[15:0], 16'h0});
                chk("R8 store count", 32'(nstores - s0), 32'd11);
            end
        end

        // R7: byte loads over every lane
        dmem[16] = 32'h807F01FE; dmem[17] = 32'h00FF55AA;
        dmem[18] = 32'h12C33C80; dmem[19] = 32'hFFFF0000;
        for (int i = 0; i < 4; i++) snap[i] = dmem[16 + i];
        clear_imem();
        for (int k = 0; k < 16; k++) begin
            imem[2*k]     = e_i(6'h20, 6, 0, 16'(64 + k));
            imem[2*k + 1] = e_i(6'h2B, 6, 0, 16'(128 + 4*k));
        end
        imem[32] = e_i(6'h09, 7, 0, 16'd80);
        imem[33] = e_i(6'h20, 6, 7, 16'hFFF5);
        imem[34] = e_i(6'h2B, 6, 0, 16'd192);
        imem[35] = e_j(35);
        restart();
        run(40);
        for (int k = 0; k < 16; k++) begin
            logic [7:0] by;
            by = snap[k/4][8*(3 - k%4) +: 8];
            chk("R7 lb lane", dmem[32 + k], {{24{by[7]}}, by});
        end
        chk("R7 lb negative offset", dmem[48], 32'hFFFFFFFF);

        // R9, R11, R12
        dmem[54] = 32'hDEADBEEF;
        clear_imem();
        imem[0]  = e_i(6'h09, 2, 0, 16'd3);
        imem[1]  = e_i(6'h09, 0, 0, 16'd5);
        imem[2]  = e_i(6'h2B, 0, 0, 16'd200);
        imem[3]  = e_i(6'h09, 1, 0, 16'd1);
        imem[4]  = e_i(6'h04, 1, 1, 16'd1);
        imem[5]  = e_i(6'h09, 2, 0, 16'd7);
        imem[6]  = e_i(6'h2B, 2, 0, 16'd204);
        imem[7]  = e_i(6'h04, 0, 1, 16'd1);
        imem[8]  = e_i(6'h09, 3, 0, 16'd9);
        imem[9]  = e_i(6'h2B, 3, 0, 16'd208);
        imem[10] = {6'h3F, 5'd0, 5'd3, 16'h0005};
        imem[11] = e_r(6'h3F, 3, 1, 1);
        imem[12] = e_i(6'h2B, 3, 0, 16'd212);
        imem[13] = e_i(6'h04, 0, 0, 16'd2);
        imem[14] = e_i(6'h2B, 1, 0, 16'd216);
        imem[15] = e_i(6'h2B, 1, 0, 16'd216);
        imem[16] = e_j(16);
        restart();
        s0 = nstores;
        run(25);
        chk("R11 zero register", dmem[50], 32'd0);
        chk("R9 taken branch skips", dmem[51], 32'd3);
        chk("R9 not-taken falls through", dmem[52], 32'd9);
        chk("R12 undefined leaves rt/rd", dmem[53], 32'd9);
        chk("R9 forward branch skips stores", dmem[54], 32'hDEADBEEF);
        chk("R12 store count", 32'(nstores - s0), 32'd4);
        chk("R9 ends at word 16", 32'(imem_addr), 32'd16);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule